// File: doc/BRIEF.md
# Byte-Lane Static Memory Core

A functional, clock-sampled model of a 16-bit-wide static memory with two independently controlled byte lanes. The control pins are active low: a chip select, an output enable, a write enable and one enable per byte. The bidirectional data bus is split into a write-data input, a read-data output and a per-lane drive vector, so that a memory controller bench can check high-impedance behaviour without real tri-state nets.

All control inputs and the address are sampled on the rising edge of `clk_i`. A write updates the array at that edge. A read, or any cycle that releases the bus, is seen on `rdata_o` and `lane_oe_o` after that edge, so there is one cycle of latency. Write enable has priority over output enable. Each lane is read, written and released on its own enable. The address width is a parameter. The full-size device uses 18 address bits, which gives 262,144 words. The default is kept small so that elaboration stays light.

Top module: `byte_lane_sram`

## Requirements
- R1: The array holds 2**ADDR_W words of 16 bits, and every address from 0 to 2**ADDR_W-1 stores its own word. The full-size configuration is ADDR_W = 18.
- R2: When cs_ni is high at an edge, nothing is written, and in the following cycle lane_oe_o is 2'b00, whatever the other inputs are.
- R3: When cs_ni=0, oe_ni=0 and we_ni=1 at an edge, in the following cycle each lane whose byte enable was low is driven (its lane_oe_o bit is 1) and carries that lane of the word stored at the sampled address.
- R4: When cs_ni=0 and we_ni=0 at an edge, the lanes whose byte enable is low are written from wdata_i at that edge, whatever oe_ni is.
- R5: lb_ni governs bits 7:0 and lane_oe_o[0]. ub_ni governs bits 15:8 and lane_oe_o[1].
- R6: With cs_ni=0, we_ni=1 and oe_ni=1, no lane is driven in the following cycle and the array does not change.
- R7: An edge with we_ni=0 leaves lane_oe_o at 2'b00 in the following cycle.
- R8: During a write, a lane whose byte enable is high keeps its previous contents.
- R9: With both byte enables high in a selected cycle, nothing is written and no lane is driven.
- R10: Every bit of rdata_o that belongs to an undriven lane reads 0.
- R11: While rst_ni is low, lane_oe_o and rdata_o are 0. Reset does not clear the array.
- R12: A read at the edge right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset of the output stage, active low |
| cs_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low; has priority over oe_ni |
| lb_ni | input | 1 | Lower byte enable (bits 7:0), active low |
| ub_ni | input | 1 | Upper byte enable (bits 15:8), active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data; 0 on undriven lanes |
| lane_oe_o | output | 2 | Drive enable per lane: bit 0 lower, bit 1 upper |

## Verification
A corrupt array word shows up one cycle after the next read of that address, and only on the lane that was damaged. A lane enable that is crossed or decoded wrongly shows up in lane_oe_o, or as non-zero bits on a lane that should be idle, one cycle after the offending input. The bench first fills every address and then runs a mix of directed and random operations. Its reference model predicts both outputs after every edge, so any divergence is reported in the cycle where it first appears.

// File: rtl/sram_core_pkg.sv
package sram_core_pkg;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = 2;
  localparam int DATA_W    = LANE_W * NUM_LANES;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_QUIET = 2'd3
  } mode_e;
endpackage

// File: rtl/sram_ctrl_decode.sv
module sram_ctrl_decode
  import sram_core_pkg::*;
#(
  parameter int LANES = NUM_LANES
) (
  input  logic             cs_ni,
  input  logic             oe_ni,
  input  logic             we_ni,
  input  logic [LANES-1:0] be_ni,
  output mode_e            mode_o,
  output logic [LANES-1:0] rd_en_o,
  output logic [LANES-1:0] wr_en_o
);
  always_comb begin
    if (cs_ni)       mode_o = MODE_IDLE;
    else if (!we_ni) mode_o = MODE_WRITE;  // write wins over output enable
    else if (!oe_ni) mode_o = MODE_READ;
    else             mode_o = MODE_QUIET;
  end

  assign rd_en_o = (mode_o == MODE_READ)  ? ~be_ni : '0;
  assign wr_en_o = (mode_o == MODE_WRITE) ? ~be_ni : '0;
endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
  parameter int ADDR_W = 10,
  parameter int WIDTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic              drive_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      drive_o <= rd_en_i;
      rdata_o <= rd_en_i ? mem_q[addr_i] : '0;
    end
  end

  assert_rd_wr_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && rd_en_i));

  assert_idle_lane_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> (rdata_o == '0));
endmodule

// File: rtl/byte_lane_sram.sv
module byte_lane_sram
  import sram_core_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 oe_ni,
  input  logic                 we_ni,
  input  logic                 lb_ni,
  input  logic                 ub_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [NUM_LANES-1:0] lane_oe_o
);
  mode_e                mode;
  logic [NUM_LANES-1:0] rd_en, wr_en;

  sram_ctrl_decode #(.LANES(NUM_LANES)) i_decode (
    .cs_ni   (cs_ni),
    .oe_ni   (oe_ni),
    .we_ni   (we_ni),
    .be_ni   ({ub_ni, lb_ni}),
    .mode_o  (mode),
    .rd_en_o (rd_en),
    .wr_en_o (wr_en)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    sram_lane_bank #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) i_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .addr_i  (addr_i),
      .wr_en_i (wr_en[g]),
      .rd_en_i (rd_en[g]),
      .wdata_i (wdata_i[g*LANE_W +: LANE_W]),
      .rdata_o (rdata_o[g*LANE_W +: LANE_W]),
      .drive_o (lane_oe_o[g])
    );
  end

  logic past_valid_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_valid_q <= 1'b0;
    else         past_valid_q <= 1'b1;
  end

  assert_standby_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid_q && $past(cs_ni) |-> lane_oe_o == '0);

  assert_read_lanes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid_q && $past(mode == MODE_READ) |-> lane_oe_o == ~$past({ub_ni, lb_ni}));

  assert_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid_q && $past(!cs_ni && oe_ni && we_ni) |-> lane_oe_o == '0);

  assert_write_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid_q && $past(!we_ni) |-> lane_oe_o == '0);

  assert_no_lane_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid_q && $past(lb_ni && ub_ni) |-> lane_oe_o == '0);

  always_comb begin
    if (!rst_ni) assert_reset_R11: assert (lane_oe_o == '0 && rdata_o == '0);
  end
endmodule

// File: tb/test_byte_lane_sram.sv
module test_byte_lane_sram;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1, lb_ni = 1'b1, ub_ni = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [1:0]  lane_oe_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [15:0] model [DEPTH];

  always #10 clk_i = ~clk_i;

  byte_lane_sram #(.ADDR_W(ADDR_W)) i_byte_lane_sram (
    .clk_i, .rst_ni, .cs_ni, .oe_ni, .we_ni, .lb_ni, .ub_ni,
    .addr_i, .wdata_i, .rdata_o, .lane_oe_o
  );

  task automatic check(input string tag, input logic [1:0] e_oe, input logic [15:0] e_d);
    checks++;
    if (lane_oe_o !== e_oe || rdata_o !== e_d) begin
      errors++;
      $display("FAIL %s: lane_oe=%b rdata=%h expected lane_oe=%b rdata=%h",
               tag, lane_oe_o, rdata_o, e_oe, e_d);
    end
  endtask

  // Drive one cycle, predict the outputs after the edge, compare.
  task automatic step(input bit cs, input bit oe, input bit we, input bit lb, input bit ub,
                      input int a, input logic [15:0] d, input string tag);
    logic [1:0]  e_oe = 2'b00;
    logic [15:0] e_d  = 16'h0;
    cs_ni = cs; oe_ni = oe; we_ni = we; lb_ni = lb; ub_ni = ub;
    addr_i = a[ADDR_W-1:0]; wdata_i = d;
    if (!cs && we && !oe) begin
      e_oe = {!ub, !lb};
      if (!lb) e_d[7:0]  = model[a][7:0];
      if (!ub) e_d[15:8] = model[a][15:8];
    end
    if (!cs && !we) begin
      if (!lb) model[a][7:0]  = d[7:0];
      if (!ub) model[a][15:8] = d[15:8];
    end
    @(posedge clk_i);
    #1;
    check(tag, e_oe, e_d);
  endtask

  task automatic rd(input int a, input string tag);
    step(0, 0, 1, 0, 0, a, 16'h0, tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    #5;
    check("R11 reset", 2'b00, 16'h0);
    @(posedge clk_i); #1;
    check("R11 reset", 2'b00, 16'h0);
    rst_ni = 1'b1;

    // R1: fill every address, read the ends
    for (int a = 0; a < DEPTH; a++)
      step(0, 1, 0, 0, 0, a, 16'((a * 16'h9e37) ^ 16'h5a5a), "R1 fill");
    rd(0, "R1 low end");
    rd(DEPTH - 1, "R1 high end");

    // R4: write with output enable low, R12: read right after
    step(0, 0, 0, 0, 0, 7, 16'h1234, "R4 write oe low");
    rd(7, "R12 read after write");

    // R5/R8: single-lane writes keep the other lane
    step(0, 1, 0, 0, 1, 7, 16'hffab, "R8 lower only write");
    rd(7, "R5 lower lane updated");
    step(0, 1, 0, 1, 0, 7, 16'hcdff, "R8 upper only write");
    rd(7, "R5 upper lane updated");

    // R10: lane-only reads, undriven lane reads 0
    step(0, 0, 1, 0, 1, 7, 16'h0, "R10 lower only read");
    step(0, 0, 1, 1, 0, 7, 16'h0, "R10 upper only read");

    // R9: no byte enable
    step(0, 0, 0, 1, 1, 7, 16'h0000, "R9 write no lanes");
    step(0, 0, 1, 1, 1, 7, 16'h0, "R9 read no lanes");
    rd(7, "R9 contents unchanged");

    // R2: deselected write attempt
    step(1, 0, 0, 0, 0, 7, 16'hdead, "R2 deselected");
    rd(7, "R2 no write while deselected");

    // R6: selected, outputs disabled
    step(0, 1, 1, 0, 0, 7, 16'hbeef, "R6 outputs disabled");

    // R7: write releases bus even after a read
    rd(8, "R3 read");
    step(0, 0, 0, 0, 0, 8, 16'h4242, "R7 write releases bus");

    // R11: mid-run reset keeps contents
    #9;
    rst_ni = 1'b0;
    #1;
    check("R11 reset mid-run", 2'b00, 16'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd(8, "R11 contents kept");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      bit cs = ($urandom_range(0, 7) == 0);
      bit oe = $urandom_range(0, 1);
      bit we = ($urandom_range(0, 2) != 0);
      bit lb = ($urandom_range(0, 3) == 0);
      bit ub = ($urandom_range(0, 3) == 0);
      int a  = $urandom_range(0, 15);
      string tag;
      if (cs)            tag = "R2 random";
      else if (!we)      tag = "R7 random";
      else if (oe)       tag = "R6 random";
      else if (lb && ub) tag = "R9 random";
      else               tag = "R3 random";
      step(cs, oe, we, lb, ub, a, 16'($urandom), tag);
    end

    done = 1;
    finish_run();
  end
endmodule